// File: doc/BRIEF.md
# Sign-Magnitude Fraction Divider (Nonrestoring)

This block divides one sign-magnitude fraction by another, one quotient bit per clock. Each operand has a sign bit and `MAG_W` magnitude bits. The magnitude bits are weighted 2^-1 down to 2^-MAG_W. The sign of the quotient is formed on its own, as the exclusive-or of the two operand signs.

The magnitudes are divided by the alternating add/subtract method. The first step subtracts the divisor magnitude from the dividend magnitude. After that, each step doubles the partial remainder. It then subtracts the divisor if the previous remainder was non-negative, or adds it if the previous remainder was negative. There is never a restore cycle. Each step yields one quotient bit, which is 1 when the new remainder is non-negative.

The bit from the first step has integer weight. If that bit is 1, the quotient does not fit in a fraction, and the block reports an error. A zero divisor is reported as an error at once. A caller pulses `start_i`, waits for the single-cycle `done_o`, and then reads the quotient, the final partial remainder and the error flag. These three outputs hold until the next accepted start.

Top module: `sm_frac_div`

## Requirements
- R1: For an error-free division, quotient bit `MAG_W` (the sign) equals the exclusive-or of the two operand sign bits. This also holds when an operand magnitude is zero.
- R2: For an error-free division, the quotient magnitude `quot_o[MAG_W-1:0]` equals floor(x*·2^MAG_W / y*). Here x* and y* are the operand magnitudes read as integers. The steps run as nonrestoring iterations: x* − y* first, then 2R − y* after a non-negative remainder or 2R + y* after a negative one.
- R3: For an error-free division, `rem_o` is the final partial remainder as a two's-complement integer in units of 2^-MAG_W. It equals x*·2^MAG_W − q·y* when the last quotient bit is 1, and that value minus y* when the last quotient bit is 0. No correction step is applied.
- R4: With `MAG_W`=5, dividing −0.10101 by +0.11011 gives the quotient 1.11000 (`quot_o`=6'b111000) and `rem_o` = −3.
- R5: With `MAG_W`=5, dividing +13/32 by −27/32 gives the quotient 1.01111 (`quot_o`=6'b101111) and `rem_o` = +11.
- R6: Consider a start accepted at clock edge k with a nonzero divisor and no overflow. `done_o` is high for exactly one cycle, following edge k+MAG_W+1. That is MAG_W+1 iterations, each taking one clock.
- R7: A start with a zero divisor magnitude runs no iterations. It raises `done_o` and `err_o` in the cycle after the start edge, with `quot_o` and `rem_o` both zero.
- R8: When x* ≥ y* (and y* is nonzero), the first step's quotient bit is 1. The block stops after that single step. It raises `done_o` and `err_o` in the cycle following edge k+1, with `quot_o` and `rem_o` both zero.
- R9: A start pulse while a division is running is ignored. The running division finishes at its own time with its own result.
- R10: After reset, `done_o`, `err_o`, `quot_o` and `rem_o` are all zero. `quot_o`, `rem_o` and `err_o` change only in a cycle where `done_o` is high, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| start_i | input | 1 | Start pulse; sampled only while the block is idle |
| dvd_sign_i | input | 1 | Dividend sign (1 = negative) |
| dvd_mag_i | input | MAG_W | Dividend magnitude, fraction bits 2^-1 down to 2^-MAG_W |
| dvs_sign_i | input | 1 | Divisor sign (1 = negative) |
| dvs_mag_i | input | MAG_W | Divisor magnitude, same weighting as the dividend |
| quot_o | output | MAG_W+1 | Quotient: sign in the top bit, magnitude below it |
| rem_o | output | MAG_W+2 | Final partial remainder, two's complement, in units of 2^-MAG_W |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero divisor or quotient overflow on the last completed division |

## Verification
The assertions check three things on every cycle: the partial remainder's two sign bits always agree, `done_o` never stays high for two cycles, and the result outputs only move together with `done_o`. They also check that a zero divisor or a first-step quotient bit of 1 is followed directly by an error completion, and that the divisor register stays still while a division runs. The arithmetic itself can only be shown by the bench scenarios. That covers the quotient bits, the sign, the uncorrected remainder, the exact completion latency, and the fact that a start during a run is ignored. The bench computes expected values by integer division and compares them at the ports.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/sm_div_rst_sync.sv
module sm_div_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sm_div_addsub.sv
// One nonrestoring step: choose the operand (unshifted on the first
// step, doubled afterwards) and the addend (-y on the first step or
// after a non-negative remainder, +y after a negative one).
module sm_div_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] ypos_i,
  input  logic [W-1:0] yneg_i,
  input  logic         first_i,
  output logic [W-1:0] sum_o,
  output logic         qbit_o
);
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W:0]   carry;

  always_comb begin
    opa = first_i ? rem_i : {rem_i[W-2:0], 1'b0};
    opb = (first_i || !rem_i[W-1]) ? yneg_i : ypos_i;
  end

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_rca
    assign sum_o[i]   = opa[i] ^ opb[i] ^ carry[i];
    assign carry[i+1] = (opa[i] & opb[i]) | (carry[i] & (opa[i] ^ opb[i]));
  end

  assign qbit_o = ~sum_o[W-1];
endmodule

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
  import sm_div_pkg::*;
#(
  parameter int MAG_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic yzero_i,
  input  logic qbit_i,
  output logic load_o,
  output logic step_o,
  output logic first_o,
  output logic finish_o,
  output logic zdiv_o,
  output logic ovf_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(MAG_W + 2);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAG_W);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             last_step;

  always_comb begin
    accept    = start_i && (state_q == ST_IDLE);
    zdiv_o    = accept && yzero_i;
    load_o    = accept && !yzero_i;
    step_o    = (state_q == ST_RUN);
    busy_o    = step_o;
    first_o   = step_o && (cnt_q == '0);
    last_step = (cnt_q == LAST_STEP);
    ovf_o     = first_o && qbit_i;
    finish_o  = step_o && (last_step || ovf_o);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load_o) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (finish_o) state_d = ST_IDLE;
        else          cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R6: a run never lasts longer than MAG_W+1 steps
  a_r6_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last_step) |=> (state_q == ST_IDLE));

  // R9: a start while running never reloads the sequence
  a_r9_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !finish_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sm_div_datapath.sv
module sm_div_datapath #(
  parameter int MAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             first_i,
  input  logic             finish_i,
  input  logic             zdiv_i,
  input  logic             ovf_i,
  input  logic             dvd_sign_i,
  input  logic [MAG_W-1:0] dvd_mag_i,
  input  logic             dvs_sign_i,
  input  logic [MAG_W-1:0] dvs_mag_i,
  output logic             qbit_o,
  output logic [MAG_W:0]   quot_o,
  output logic [MAG_W+1:0] rem_o,
  output logic             done_o,
  output logic             err_o
);
  // remainder: two sign bits plus MAG_W+1 magnitude bits
  localparam int RW = MAG_W + 3;
  localparam int OW = MAG_W + 2;

  logic [RW-1:0]    rem_q, rem_d;
  logic [RW-1:0]    ypos_q, ypos_d;
  logic [RW-1:0]    yneg_q, yneg_d;
  logic [MAG_W-1:0] qsh_q, qsh_d;
  logic             sgn_q, sgn_d;
  logic [MAG_W:0]   quot_q, quot_d;
  logic [OW-1:0]    remo_q, remo_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic [RW-1:0]    step_sum;
  logic [MAG_W:0]   qfull;

  sm_div_addsub #(.W(RW)) u_step (
    .rem_i   (rem_q),
    .ypos_i  (ypos_q),
    .yneg_i  (yneg_q),
    .first_i (first_i),
    .sum_o   (step_sum),
    .qbit_o  (qbit_o)
  );

  assign qfull = {qsh_q, qbit_o};

  always_comb begin
    rem_d  = rem_q;
    ypos_d = ypos_q;
    yneg_d = yneg_q;
    qsh_d  = qsh_q;
    sgn_d  = sgn_q;
    if (load_i) begin
      rem_d  = {{(RW-MAG_W){1'b0}}, dvd_mag_i};
      ypos_d = {{(RW-MAG_W){1'b0}}, dvs_mag_i};
      yneg_d = -{{(RW-MAG_W){1'b0}}, dvs_mag_i};
      qsh_d  = '0;
      sgn_d  = dvd_sign_i ^ dvs_sign_i;
    end else if (step_i) begin
      rem_d = step_sum;
      qsh_d = qfull[MAG_W-1:0];
    end
  end

  always_comb begin
    quot_d = quot_q;
    remo_d = remo_q;
    err_d  = err_q;
    done_d = zdiv_i || finish_i;
    if (zdiv_i || ovf_i) begin
      quot_d = '0;
      remo_d = '0;
      err_d  = 1'b1;
    end else if (finish_i) begin
      quot_d = {sgn_q, qfull[MAG_W-1:0]};
      remo_d = step_sum[OW-1:0];
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      ypos_q <= '0;
      yneg_q <= '0;
      qsh_q  <= '0;
      sgn_q  <= 1'b0;
      quot_q <= '0;
      remo_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      ypos_q <= ypos_d;
      yneg_q <= yneg_d;
      qsh_q  <= qsh_d;
      sgn_q  <= sgn_d;
      quot_q <= quot_d;
      remo_q <= remo_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = remo_q;
  assign err_o  = err_q;
  assign done_o = done_q;

  // R2: the two remainder sign bits always agree (no remainder overflow)
  a_r2_dbl_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q[RW-1] == rem_q[RW-2]);

  // R8: an integer quotient bit of 1 ends the run with an error
  a_r8_ovf_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (err_o && done_o && quot_o == '0));

  // R9: the divisor is held steady while the steps run
  a_r9_dvs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> $stable(ypos_q));
endmodule

// File: rtl/sm_frac_div.sv
module sm_frac_div #(
  parameter int MAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dvd_sign_i,
  input  logic [MAG_W-1:0] dvd_mag_i,
  input  logic             dvs_sign_i,
  input  logic [MAG_W-1:0] dvs_mag_i,
  output logic [MAG_W:0]   quot_o,
  output logic [MAG_W+1:0] rem_o,
  output logic             done_o,
  output logic             err_o
);
  logic rst_n;
  logic load, step, first, finish, zdiv, ovf, busy, qbit;
  logic yzero;

  assign yzero = (dvs_mag_i == '0);

  sm_div_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  sm_div_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (start_i),
    .yzero_i  (yzero),
    .qbit_i   (qbit),
    .load_o   (load),
    .step_o   (step),
    .first_o  (first),
    .finish_o (finish),
    .zdiv_o   (zdiv),
    .ovf_o    (ovf),
    .busy_o   (busy)
  );

  sm_div_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (load),
    .step_i     (step),
    .first_i    (first),
    .finish_i   (finish),
    .zdiv_i     (zdiv),
    .ovf_i      (ovf),
    .dvd_sign_i (dvd_sign_i),
    .dvd_mag_i  (dvd_mag_i),
    .dvs_sign_i (dvs_sign_i),
    .dvs_mag_i  (dvs_mag_i),
    .qbit_o     (qbit),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: an idle start with a zero divisor completes at once with an error
  a_r7_zero_div: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy && yzero) |=> (done_o && err_o && quot_o == '0));

  // R10: results move only together with the completion pulse
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!$stable(quot_o) || !$stable(rem_o) || !$stable(err_o)) |-> done_o);
endmodule

// File: tb/tb_sm_frac_div.sv
module tb_sm_frac_div;
  localparam int N = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic           xs, ys;
  logic [N-1:0]   xm, ym;
  logic [N:0]     quot;
  logic [N+1:0]   rem;
  logic           done, err;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sm_frac_div #(.MAG_W(N)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .dvd_sign_i (xs),
    .dvd_mag_i  (xm),
    .dvs_sign_i (ys),
    .dvs_mag_i  (ym),
    .quot_o     (quot),
    .rem_o      (rem),
    .done_o     (done),
    .err_o      (err)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Launch one division; leaves the bench at the negedge after the start edge.
  task automatic launch(input logic sx, input int mx, input logic sy, input int my);
    @(negedge clk);
    xs = sx; xm = N'(mx); ys = sy; ym = N'(my);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Count edges after the start edge until done is seen.
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_div(input string req, input logic sx, input int mx,
                         input logic sy, input int my, input bit busy_poke);
    int cyc, q, r, exp_lat, exp_rem;
    logic exp_err;
    logic [N:0] exp_q;
    launch(sx, mx, sy, my);
    if (my == 0) begin
      exp_err = 1'b1; exp_lat = 0; exp_q = '0; exp_rem = 0;
    end else if (mx >= my) begin
      exp_err = 1'b1; exp_lat = 1; exp_q = '0; exp_rem = 0;
    end else begin
      q = (mx << N) / my;
      r = (mx << N) - q * my;
      exp_rem = (q % 2 == 1) ? r : r - my;
      exp_err = 1'b0; exp_lat = N + 1;
      exp_q = {sx ^ sy, N'(q)};
    end
    if (busy_poke && exp_lat > 2) begin
      // R9: a second start during the run, with different operands
      @(negedge clk);
      xs = ~sx; xm = N'(1); ys = sy; ym = N'(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      cyc = cyc + 2;
    end else begin
      wait_done(cyc);
    end
    check(req, "latency", cyc, exp_lat);
    check(req, "error flag", err, exp_err);
    check(req, "quotient", quot, exp_q);
    check(req, "remainder", longint'($signed(rem)), exp_rem);
    // R6: one-cycle pulse
    @(negedge clk);
    check("R6", "done drops", done, 0);
    // R10: hold until next start
    repeat (3) @(negedge clk);
    check("R10", "quot held", quot, exp_q);
    check("R10", "err held", err, exp_err);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    xs = 1'b0; ys = 1'b0; xm = '0; ym = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset done", done, 0);
    check("R10", "reset err", err, 0);
    check("R10", "reset quot", quot, 0);
    check("R10", "reset rem", rem, 0);

    run_div("R4", 1'b1, 21, 1'b0, 27, 1'b0);
    run_div("R5", 1'b0, 13, 1'b1, 27, 1'b0);
    run_div("R1", 1'b1, 3, 1'b1, 17, 1'b0);
    run_div("R1", 1'b1, 0, 1'b0, 9, 1'b0);
    run_div("R2", 1'b0, 30, 1'b0, 31, 1'b0);
    run_div("R2", 1'b0, 1, 1'b0, 31, 1'b0);
    run_div("R3", 1'b1, 7, 1'b1, 12, 1'b0);
    run_div("R7", 1'b0, 9, 1'b1, 0, 1'b0);
    run_div("R8", 1'b0, 20, 1'b0, 20, 1'b0);
    run_div("R8", 1'b1, 31, 1'b0, 4, 1'b0);
    run_div("R9", 1'b0, 11, 1'b1, 19, 1'b1);
    run_div("R6", 1'b0, 5, 1'b0, 6, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule